// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block takes a wide vector of general-purpose input pins and steers one chosen pin onto each of eight interrupt lines. Each line has its own trigger rule. The rule can be a level of either sense, a rising edge, a falling edge or any transition. Software sets up the block through a small word-addressed register port. It writes which pin feeds which line and how that line triggers, and it acknowledges edge events that have latched.

The pins are asynchronous to the block clock, so they pass through a two-flop synchronizer before any use. A level-triggered line follows its qualified pin with no stored state. An edge-triggered line keeps a sticky pending flag that drives the output until software writes a one to that line's bit in the acknowledge register. A single master enable bit forces every line low when it is clear.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, every register reads 0 and every interrupt output is 0.
- R2: The control word is at byte offset 0x00. Bit 31 is the master enable, bits 23:16 are the any-edge enables, bits 15:8 the one-edge enables and bits 7:0 the active-low selects, with bit n of each field belonging to line n. Bits 30:24 read 0 and ignore writes. Offsets 0x18 and above read 0.
- R3: While the master enable is 0, all eight outputs are 0 whatever the pins and the other settings are.
- R4: Line c takes its source pin index from the register at 0x04 + 4*(c/2). An even line uses bits 6:0 of that register and an odd line uses bits 22:16. All other bits of these registers read 0 and ignore writes.
- R5: A source index from 62 to 127 selects no pin, and the line sees a constant 0. An active-low level line with such an index therefore asserts.
- R6: Level mode applies when the any-edge and one-edge bits are both 0. With active-low clear the output equals the pin; with it set the output equals the inverted pin. The output changes after the second rising clock edge that follows a pin change.
- R7: Rising mode (one-edge 1, active-low 0, any-edge 0) sets a pending flag on a 0-to-1 change of the synchronized pin. The output shows the flag after the third clock edge, and the flag stays set after the pin returns.
- R8: Falling mode (one-edge 1, active-low 1, any-edge 0) sets the flag on a 1-to-0 change only.
- R9: When the any-edge bit is 1, either transition sets the flag, whatever the one-edge and active-low bits are.
- R10: A write to offset 0x14 clears the pending flag of every line whose data bit is 1. If an edge arrives in the same cycle as the clearing write, the flag stays set. A read of 0x14 returns the pending flags in bits 7:0.
- R11: Pending flags set only while the master enable is 1. A line in level mode has its flag cleared on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_wen | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pins_i | input | 62 | Asynchronous GPIO pin inputs |
| irq_o | output | 8 | Interrupt outputs, one per line |

## Verification
A pin change needs two clock edges to reach a level-mode output and three to reach an edge-mode output, because the pending flag adds one register after the synchronizer. Register writes and master-enable changes act on the outputs right after the edge that takes the write. The bench drives everything on falling edges and counts rising edges up to the exact edge where each result is due. For edge mode it also checks one edge earlier that the output is still low. To make a clearing write and a fresh edge coincide, the bench issues the write exactly two edges after the pin change.

// File: rtl/girq_pkg.sv
package girq_pkg;

    // Default geometry of the router
    localparam int GIRQ_PINS   = 62;
    localparam int GIRQ_CH     = 8;
    localparam int GIRQ_SEL_W  = 7;
    localparam int GIRQ_DATA_W = 32;
    localparam int GIRQ_ADDR_W = 5;

    // Control word field positions (software decodes these)
    localparam int EN_BIT      = 31;
    localparam int BOTH_LSB    = 16;
    localparam int SINGLE_LSB  = 8;
    localparam int LOW_LSB     = 0;
    localparam int ODD_SEL_LSB = 16;

    // Register window layout
    localparam int CTRL_OFS    = 0;
    localparam int SEL_OFS     = 4;
    localparam int WORD_BYTES  = 4;

    typedef enum logic [2:0] {
        TRIG_LVL_HI = 3'd0,
        TRIG_LVL_LO = 3'd1,
        TRIG_RISE   = 3'd2,
        TRIG_FALL   = 3'd3,
        TRIG_ANY    = 3'd4
    } girq_trig_e;

    typedef struct packed {
        logic                  any_edge;
        logic                  one_edge;
        logic                  act_low;
        logic [GIRQ_SEL_W-1:0] src;
    } girq_cfg_t;

    // The any-edge bit outranks the other two mode bits
    function automatic girq_trig_e girq_decode(input logic any_edge,
                                               input logic one_edge,
                                               input logic act_low);
        if (any_edge)
            return TRIG_ANY;
        if (one_edge)
            return act_low ? TRIG_FALL : TRIG_RISE;
        return act_low ? TRIG_LVL_LO : TRIG_LVL_HI;
    endfunction

    function automatic logic girq_is_edge(input girq_trig_e kind);
        return (kind == TRIG_RISE) || (kind == TRIG_FALL) || (kind == TRIG_ANY);
    endfunction

endpackage

// File: rtl/girq_regs.sv
module girq_regs
    import girq_pkg::*;
#(
    parameter int NUM_CH = GIRQ_CH,
    parameter int ADDR_W = GIRQ_ADDR_W,
    parameter int DATA_W = GIRQ_DATA_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    input  logic                          wen_i,
    input  logic [NUM_CH-1:0]             pend_i,
    output logic [DATA_W-1:0]             rdata_o,
    output logic                          glob_en_o,
    output girq_cfg_t [NUM_CH-1:0]        cfg_o,
    output logic [NUM_CH-1:0]             ack_o
);

    localparam int NUM_SEL = NUM_CH / 2;
    localparam int ACK_OFS = SEL_OFS + WORD_BYTES * NUM_SEL;

    logic                              en_q;
    logic [NUM_CH-1:0]                 both_q;
    logic [NUM_CH-1:0]                 single_q;
    logic [NUM_CH-1:0]                 low_q;
    logic [NUM_CH-1:0][GIRQ_SEL_W-1:0] src_q;

    // Bits of the write bus that no field takes
    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            both_q   <= '0;
            single_q <= '0;
            low_q    <= '0;
            src_q    <= '0;
        end else if (wen_i) begin
            if (addr_i == ADDR_W'(CTRL_OFS)) begin
                en_q     <= wdata_i[EN_BIT];
                both_q   <= wdata_i[BOTH_LSB +: NUM_CH];
                single_q <= wdata_i[SINGLE_LSB +: NUM_CH];
                low_q    <= wdata_i[LOW_LSB +: NUM_CH];
            end
            for (int k = 0; k < NUM_SEL; k++) begin
                if (addr_i == ADDR_W'(SEL_OFS + WORD_BYTES * k)) begin
                    src_q[2*k]   <= wdata_i[0 +: GIRQ_SEL_W];
                    src_q[2*k+1] <= wdata_i[ODD_SEL_LSB +: GIRQ_SEL_W];
                end
            end
        end
    end

    // Write-one-to-clear strobe toward the pending flags
    assign ack_o = (wen_i && addr_i == ADDR_W'(ACK_OFS)) ? wdata_i[NUM_CH-1:0] : '0;

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(CTRL_OFS)) begin
            rdata_o[EN_BIT]                = en_q;
            rdata_o[BOTH_LSB +: NUM_CH]    = both_q;
            rdata_o[SINGLE_LSB +: NUM_CH]  = single_q;
            rdata_o[LOW_LSB +: NUM_CH]     = low_q;
        end
        for (int k = 0; k < NUM_SEL; k++) begin
            if (addr_i == ADDR_W'(SEL_OFS + WORD_BYTES * k)) begin
                rdata_o[0 +: GIRQ_SEL_W]           = src_q[2*k];
                rdata_o[ODD_SEL_LSB +: GIRQ_SEL_W] = src_q[2*k+1];
            end
        end
        if (addr_i == ADDR_W'(ACK_OFS))
            rdata_o[0 +: NUM_CH] = pend_i;
    end

    assign glob_en_o = en_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
        assign cfg_o[c] = {both_q[c], single_q[c], low_q[c], src_q[c]};
    end

endmodule

// File: rtl/girq_pin_sync.sv
module girq_pin_sync
    import girq_pkg::*;
#(
    parameter int NUM_PINS = GIRQ_PINS,
    parameter int NUM_CH   = GIRQ_CH
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_PINS-1:0]               pins_i,
    input  logic [NUM_CH-1:0][GIRQ_SEL_W-1:0] src_i,
    output logic [NUM_CH-1:0]                 now_o,
    output logic [NUM_CH-1:0]                 prev_o
);

    localparam int SPAN = 1 << GIRQ_SEL_W;
    localparam int PAD  = SPAN - NUM_PINS;

    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0] hist_q;
    logic [SPAN-1:0]     sync_pad;
    logic [SPAN-1:0]     hist_pad;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pins_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    // Indices past the last pin land on zero padding
    if (PAD > 0) begin : g_pad
        assign sync_pad = {{PAD{1'b0}}, sync_q};
        assign hist_pad = {{PAD{1'b0}}, hist_q};
    end else begin : g_nopad
        assign sync_pad = sync_q[SPAN-1:0];
        assign hist_pad = hist_q[SPAN-1:0];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        assign now_o[c]  = sync_pad[src_i[c]];
        assign prev_o[c] = hist_pad[src_i[c]];
    end

endmodule

// File: rtl/girq_chan_trig.sv
module girq_chan_trig
    import girq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic any_edge_i,
    input  logic one_edge_i,
    input  logic act_low_i,
    input  logic glob_en_i,
    input  logic now_i,
    input  logic prev_i,
    input  logic ack_i,
    output logic irq_o,
    output logic pend_o,
    output logic hit_o,
    output logic edge_mode_o
);

    girq_trig_e kind;
    logic       pend_q;
    logic       pend_d;
    logic       level_val;

    assign kind        = girq_decode(any_edge_i, one_edge_i, act_low_i);
    assign edge_mode_o = girq_is_edge(kind);

    always_comb begin
        unique case (kind)
            TRIG_RISE: hit_o = now_i & ~prev_i;
            TRIG_FALL: hit_o = ~now_i & prev_i;
            TRIG_ANY:  hit_o = now_i ^ prev_i;
            default:   hit_o = 1'b0;
        endcase
    end

    // Edge beats acknowledge; level mode keeps nothing
    always_comb begin
        if (!edge_mode_o)
            pend_d = 1'b0;
        else if (hit_o && glob_en_i)
            pend_d = 1'b1;
        else if (ack_i)
            pend_d = 1'b0;
        else
            pend_d = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else
            pend_q <= pend_d;
    end

    assign level_val = (kind == TRIG_LVL_LO) ? ~now_i : now_i;
    assign pend_o    = pend_q;
    assign irq_o     = glob_en_i & (edge_mode_o ? pend_q : level_val);

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import girq_pkg::*;
#(
    parameter int NUM_PINS = GIRQ_PINS,
    parameter int NUM_CH   = GIRQ_CH,
    parameter int ADDR_W   = GIRQ_ADDR_W,
    parameter int DATA_W   = GIRQ_DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                reg_wen,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [NUM_CH-1:0]   irq_o
);

    girq_cfg_t [NUM_CH-1:0]              cfg_v;
    logic [NUM_CH-1:0][GIRQ_SEL_W-1:0]   src_v;
    logic                                glob_en;
    logic [NUM_CH-1:0]                   ack_v;
    logic [NUM_CH-1:0]                   pend_v;
    logic [NUM_CH-1:0]                   hit_v;
    logic [NUM_CH-1:0]                   edge_mode_v;
    logic [NUM_CH-1:0]                   now_v;
    logic [NUM_CH-1:0]                   prev_v;

    girq_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .wen_i     (reg_wen),
        .pend_i    (pend_v),
        .rdata_o   (reg_rdata),
        .glob_en_o (glob_en),
        .cfg_o     (cfg_v),
        .ack_o     (ack_v)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_src
        assign src_v[c] = cfg_v[c].src;
    end

    girq_pin_sync #(
        .NUM_PINS (NUM_PINS),
        .NUM_CH   (NUM_CH)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_i),
        .src_i  (src_v),
        .now_o  (now_v),
        .prev_o (prev_v)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        girq_chan_trig u_trig (
            .clk         (clk),
            .rst         (rst),
            .any_edge_i  (cfg_v[c].any_edge),
            .one_edge_i  (cfg_v[c].one_edge),
            .act_low_i   (cfg_v[c].act_low),
            .glob_en_i   (glob_en),
            .now_i       (now_v[c]),
            .prev_i      (prev_v[c]),
            .ack_i       (ack_v[c]),
            .irq_o       (irq_o[c]),
            .pend_o      (pend_v[c]),
            .hit_o       (hit_v[c]),
            .edge_mode_o (edge_mode_v[c])
        );
    end

endmodule

// File: rtl/girq_checker.sv
module girq_checker #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] irq_o,
    input logic              glob_en,
    input logic [NUM_CH-1:0] edge_mode,
    input logic [NUM_CH-1:0] hit,
    input logic [NUM_CH-1:0] ack,
    input logic [NUM_CH-1:0] pend
);

    // R3: master enable low silences every line
    p_gate_r3: assert property (@(posedge clk) disable iff (rst)
        !glob_en |-> (irq_o == '0));

    // R7: a qualifying edge while enabled leaves its flag set
    p_edge_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (glob_en && ((hit & edge_mode) != '0))
        |=> ((pend & $past(hit & edge_mode)) == $past(hit & edge_mode)));

    // R10: an acknowledge with no coincident edge clears the flag
    p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
        ((ack & ~hit) != '0) |=> ((pend & $past(ack & ~hit)) == '0));

    // R10: an edge in the acknowledge cycle keeps the flag
    p_edge_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (glob_en && ((ack & hit & edge_mode) != '0))
        |=> ((pend & $past(ack & hit & edge_mode)) == $past(ack & hit & edge_mode)));

    // R11: a line in level mode holds no flag one edge later
    p_level_clear_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & ~$past(edge_mode)) == '0));

    // R11: with the enable low no flag can rise
    p_no_set_off_r11: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> ((pend & ~$past(pend)) == '0));

endmodule

bind gpio_irq_router girq_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_o     (irq_o),
    .glob_en   (glob_en),
    .edge_mode (edge_mode_v),
    .hit       (hit_v),
    .ack       (ack_v),
    .pend      (pend_v)
);

// File: tb/gpio_irq_router_test.sv
`timescale 1ns/1ps
module gpio_irq_router_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_rdata;
    logic [61:0] pins = '0;
    logic [7:0]  irq;

    int nchk  = 0;
    int nfail = 0;

    localparam logic [31:0] EN   = 32'h8000_0000;
    localparam logic [31:0] UNM2 = 32'h007F_007F;

    always #10 clk = ~clk;

    gpio_irq_router uut (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wen   (reg_wen),
        .reg_rdata (reg_rdata),
        .pins_i    (pins),
        .irq_o     (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(negedge clk);
        reg_wen   = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [4:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic irqchk(input string req, input logic [7:0] exp);
        #1;
        chk(req, {24'b0, irq}, {24'b0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1: reset state
        for (int a = 0; a <= 20; a += 4) rdchk("R1 reg reset", 5'(a), 32'h0);
        irqchk("R1 irq reset", 8'h00);

        // R2: control word masking and unmapped offsets
        wr(5'h00, 32'hFFFF_FFFF);
        rdchk("R2 ctrl mask", 5'h00, 32'h80FF_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
        rdchk("R2 beyond window", 5'h18, 32'h0);
        rdchk("R2 beyond window", 5'h1C, 32'h0);
        // R4: select register masking
        wr(5'h0C, 32'hFFFF_FFFF);
        rdchk("R4 sel mask", 5'h0C, 32'h007F_007F);

        // All lines unmapped, level high, enabled
        for (int k = 0; k < 4; k++) wr(5'(4 + 4 * k), UNM2);
        wr(5'h00, EN);
        irqchk("R5 unmapped level high", 8'h00);

        // R4: sweep every line over every pin
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 62; p++) begin
                logic [31:0] v;
                v = (c % 2 == 0) ? (32'h007F_0000 | 32'(p)) : (32'h0000_007F | (32'(p) << 16));
                wr(5'(4 + 4 * (c / 2)), v);
                pins = 62'd1 << p;
                tick(2);
                irqchk("R4 R6 selected pin high", 8'(1 << c));
                pins = ~(62'd1 << p);
                tick(2);
                irqchk("R4 selected pin low", 8'h00);
                wr(5'(4 + 4 * (c / 2)), UNM2);
            end
        end
        pins = '0;
        tick(3);

        // Line 3 on pin 40
        wr(5'h08, (32'd40 << 16) | 32'h7F);

        // R7: rising edge, sticky, 3-edge latency
        wr(5'h00, EN | (32'd1 << 11));
        pins[40] = 1'b1;
        tick(2);
        irqchk("R7 not yet after two edges", 8'h00);
        tick(1);
        irqchk("R7 rising latched", 8'h08);
        pins[40] = 1'b0;
        tick(3);
        irqchk("R7 sticky after pin drops", 8'h08);
        rdchk("R10 pending readback", 5'h14, 32'h08);
        wr(5'h14, 32'h08);
        irqchk("R10 acknowledge clears", 8'h00);
        rdchk("R10 pending cleared", 5'h14, 32'h00);

        // R8: falling edge only
        wr(5'h00, EN | (32'd1 << 11) | (32'd1 << 3));
        pins[40] = 1'b1;
        tick(3);
        irqchk("R8 rise ignored", 8'h00);
        pins[40] = 1'b0;
        tick(3);
        irqchk("R8 fall latched", 8'h08);
        wr(5'h14, 32'h08);
        irqchk("R10 clear after fall", 8'h00);

        // R9: any-edge overrides active-low
        wr(5'h00, EN | (32'd1 << 19) | (32'd1 << 3));
        pins[40] = 1'b1;
        tick(3);
        irqchk("R9 rise with any-edge", 8'h08);
        wr(5'h14, 32'h08);
        irqchk("R10 clear any-edge", 8'h00);
        pins[40] = 1'b0;
        tick(3);
        irqchk("R9 fall with any-edge", 8'h08);

        // R10: edge and clear in the same cycle
        pins[40] = 1'b1;
        tick(2);
        wr(5'h14, 32'h08);
        irqchk("R10 edge wins over clear", 8'h08);
        wr(5'h14, 32'h08);
        irqchk("R10 plain clear", 8'h00);

        // R6: active-low level with its latency
        wr(5'h00, EN | (32'd1 << 3));
        irqchk("R6 low level pin high", 8'h00);
        pins[40] = 1'b0;
        tick(1);
        irqchk("R6 not yet after one edge", 8'h00);
        tick(1);
        irqchk("R6 low level asserted", 8'h08);
        wr(5'h00, EN);
        irqchk("R6 high level pin low", 8'h00);
        pins[40] = 1'b1;
        tick(2);
        irqchk("R6 high level asserted", 8'h08);

        // R3: enable off masks all
        wr(5'h00, 32'h0000_00FF);
        irqchk("R3 disabled active-low", 8'h00);
        // R5: unmapped lines see 0, so active-low asserts
        wr(5'h00, EN | 32'h0000_00FF);
        irqchk("R5 unmapped active-low", 8'hF7);

        // R11: no flag while disabled
        wr(5'h00, 32'd1 << 11);
        pins[40] = 1'b0;
        tick(3);
        pins[40] = 1'b1;
        tick(3);
        rdchk("R11 no pending while disabled", 5'h14, 32'h00);
        wr(5'h00, EN | (32'd1 << 11));
        irqchk("R11 enabling shows nothing", 8'h00);
        pins[40] = 1'b0;
        tick(3);
        pins[40] = 1'b1;
        tick(3);
        irqchk("R7 rising again", 8'h08);
        // R11: level mode drops the flag
        wr(5'h00, EN | (32'd1 << 3));
        tick(1);
        rdchk("R11 level mode clears flag", 5'h14, 32'h00);
        wr(5'h00, EN | (32'd1 << 11));
        tick(3);
        irqchk("R11 flag stays cleared", 8'h00);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule